// File: doc/BRIEF.md
# Banked Flash Window with Program-Write Redirect

This block lets a processor with a 16-bit address space reach a flash array larger than 64 KB. The lower half of the processor space (address bit 15 clear) maps straight onto the first 32 KB of flash. The upper half (address bit 15 set) is a 32 KB window. A bank register chooses which 32 KB slice of flash appears in that window, so the flash address is the bank value joined to the low fifteen address bits. The bank field is two or three bits wide, chosen by a parameter, which gives 128 KB or 256 KB of flash.

The same block steers external-data write cycles. A program-write enable bit chooses the target. With the bit clear, each write cycle raises a one-cycle strobe toward XRAM. With the bit set, the write byte goes into flash at the mapped address, and the XRAM strobe stays low. Software must clear the enable after each programmed byte, because hardware never clears it. A write to the enable bit is dropped while the processor's global interrupt enable is high. An erase-complete pulse from the flash controller returns the bank register to zero.

All outputs are registered, so they appear one clock after the inputs that cause them.

Top module: `flash_bank_window`

## Requirements
- R1: With cpu_addr[15]=1, flash_addr one cycle later equals {bank, cpu_addr[14:0]}, using the bank value held before that clock edge.
- R2: With cpu_addr[15]=0, flash_addr one cycle later has all bits above bit 14 at zero and bits 14:0 equal to cpu_addr[14:0].
- R3: A register write with reg_sel=0 loads reg_wdata[BANK_W-1:0] into the bank. Higher data bits are discarded. BANK_W is 2 or 3.
- R4: erase_done=1 at a clock edge clears the bank. If a bank write arrives at the same edge, the clear takes priority.
- R5: With the enable bit at 0, a write cycle gives xram_we=1 for one cycle and flash_we=0.
- R6: With the enable bit at 1, a write cycle gives flash_we=1 for one cycle, with flash_wdata equal to the write byte and flash_addr equal to the mapped address. xram_we stays 0 in that cycle.
- R7: A register write with reg_sel=1 loads reg_wdata[0] into the enable bit. The write is ignored when cpu_ea=1 at that edge.
- R8: The enable bit stays set after a flash byte write. Further write cycles keep going to flash until software clears the bit.
- R9: A write cycle is the rising edge of cpu_xwr. Holding cpu_xwr high for several cycles gives exactly one strobe.
- R10: rst=1 clears the bank and the enable bit. It also holds flash_we, xram_we and flash_addr at zero.
- R11: A write cycle at the same edge as a register write is routed and mapped using the register values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Register write request |
| reg_sel | input | 1 | 0 = bank register, 1 = program-write control |
| reg_wdata | input | 8 | Register write data |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_xwr | input | 1 | External-data write strobe (level; the rising edge starts a cycle) |
| cpu_ea | input | 1 | Global interrupt enable status |
| erase_done | input | 1 | Erase-cycle completion pulse |
| flash_addr | output | BANK_W+15 | Mapped flash byte address |
| flash_wdata | output | 8 | Byte to be programmed |
| flash_we | output | 1 | One-cycle flash program strobe |
| xram_we | output | 1 | One-cycle XRAM write strobe |

## Verification
The assertions check on every cycle that the two strobes never fire together and that no strobe lasts more than one cycle. They also check that a flash strobe only follows a set enable bit, that the enable bit holds while interrupts are on, and that an erase or reset empties the bank. The same checks cover the bit-15 split of the mapped address. Only the bench scenarios can show the routing in practice: that software must clear the enable after programming, that same-edge register writes lose to the write cycle and to erase, that upper data bits are dropped for both bank widths, and which byte lands at which flash address.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

    localparam int CPU_AW  = 16;
    localparam int WIN_AW  = 15;
    localparam int DATA_W  = 8;

    typedef enum logic {
        SEL_BANK = 1'b0,
        SEL_CTRL = 1'b1
    } regsel_e;

    typedef enum logic [1:0] {
        RT_IDLE  = 2'b00,
        RT_XRAM  = 2'b01,
        RT_FLASH = 2'b10
    } route_e;

    typedef struct packed {
        logic [CPU_AW-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              strobe;
    } cpu_req_t;

    function automatic route_e pick_route(input logic fresh, input logic prog_en);
        if (!fresh)
            return RT_IDLE;
        else if (prog_en)
            return RT_FLASH;
        else
            return RT_XRAM;
    endfunction

endpackage

// File: rtl/fbw_regs.sv
module fbw_regs
    import fbw_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  regsel_e           sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ea,
    input  logic              erase_done,
    output logic [BANK_W-1:0] bank,
    output logic              prog_en
);

    logic bank_hit;
    logic ctrl_hit;

    assign bank_hit = wr_en && (sel == SEL_BANK);
    assign ctrl_hit = wr_en && (sel == SEL_CTRL) && !ea;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= '0;
        end else if (erase_done) begin
            bank <= '0;
        end else if (bank_hit) begin
            bank <= wdata[BANK_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_en <= 1'b0;
        end else if (ctrl_hit) begin
            prog_en <= wdata[0];
        end
    end

endmodule

// File: rtl/fbw_addr_map.sv
module fbw_addr_map
    import fbw_pkg::*;
#(
    parameter int BANK_W = 3,
    localparam int FA_W  = BANK_W + WIN_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  cpu_req_t          req,
    input  logic [BANK_W-1:0] bank,
    output logic [FA_W-1:0]   flash_addr,
    output logic [DATA_W-1:0] flash_wdata
);

    logic [FA_W-1:0]   mapped;
    logic [BANK_W-1:0] hi_part;

    generate
        if (BANK_W > 0) begin : g_hi
            assign hi_part = req.addr[CPU_AW-1] ? bank : '0;
        end
    endgenerate

    assign mapped = {hi_part, req.addr[WIN_AW-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            flash_addr  <= '0;
            flash_wdata <= '0;
        end else begin
            flash_addr  <= mapped;
            flash_wdata <= req.data;
        end
    end

endmodule

// File: rtl/fbw_write_route.sv
module fbw_write_route
    import fbw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic prog_en,
    output logic flash_we,
    output logic xram_we
);

    logic   strobe_d;
    logic   fresh;
    route_e route;

    assign fresh = strobe && !strobe_d;
    assign route = pick_route(fresh, prog_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_d <= 1'b0;
            flash_we <= 1'b0;
            xram_we  <= 1'b0;
        end else begin
            strobe_d <= strobe;
            flash_we <= (route == RT_FLASH);
            xram_we  <= (route == RT_XRAM);
        end
    end

endmodule

// File: rtl/flash_bank_window.sv
module flash_bank_window
    import fbw_pkg::*;
#(
    parameter int BANK_W = 3,
    localparam int FA_W  = BANK_W + WIN_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_xwr,
    input  logic              cpu_ea,
    input  logic              erase_done,
    output logic [FA_W-1:0]   flash_addr,
    output logic [7:0]        flash_wdata,
    output logic              flash_we,
    output logic              xram_we
);

    logic [BANK_W-1:0] bank_q;
    logic              pwe_q;
    regsel_e           sel;
    cpu_req_t          req;

    assign sel = regsel_e'(reg_sel);
    assign req = '{addr: cpu_addr, data: cpu_wdata, strobe: cpu_xwr};

    fbw_regs #(.BANK_W(BANK_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .sel        (sel),
        .wdata      (reg_wdata),
        .ea         (cpu_ea),
        .erase_done (erase_done),
        .bank       (bank_q),
        .prog_en    (pwe_q)
    );

    fbw_addr_map #(.BANK_W(BANK_W)) u_map (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .bank        (bank_q),
        .flash_addr  (flash_addr),
        .flash_wdata (flash_wdata)
    );

    fbw_write_route u_route (
        .clk      (clk),
        .rst      (rst),
        .strobe   (req.strobe),
        .prog_en  (pwe_q),
        .flash_we (flash_we),
        .xram_we  (xram_we)
    );

endmodule

// File: rtl/fbw_checker.sv
module fbw_checker #(
    parameter int BANK_W = 3,
    localparam int FA_W  = BANK_W + 15
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic              reg_sel,
    input logic [15:0]       cpu_addr,
    input logic              cpu_ea,
    input logic              erase_done,
    input logic [FA_W-1:0]   flash_addr,
    input logic              flash_we,
    input logic              xram_we,
    input logic [BANK_W-1:0] bank_q,
    input logic              pwe_q
);

    // R6: flash and XRAM strobes are mutually exclusive
    assert_excl_strobes_R6: assert property (@(posedge clk) disable iff (rst)
        !(flash_we && xram_we));

    // R9: a strobe never lasts two cycles
    assert_flash_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        flash_we |=> !flash_we);
    assert_xram_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        xram_we |=> !xram_we);

    // R6: a flash strobe only follows a set enable bit
    assert_flash_needs_en_R6: assert property (@(posedge clk) disable iff (rst)
        flash_we |-> $past(pwe_q));

    // R7: enable bit frozen while interrupts are on
    assert_en_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_sel && cpu_ea) |=> $stable(pwe_q));

    // R4: erase completion empties the bank
    assert_erase_clears_R4: assert property (@(posedge clk) disable iff (rst)
        erase_done |=> (bank_q == '0));

    // R10: reset empties both registers
    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (bank_q == '0 && !pwe_q && !flash_we && !xram_we));

    // R2: lower half never carries bank bits
    assert_low_half_R2: assert property (@(posedge clk) disable iff (rst)
        !cpu_addr[15] |=> (flash_addr[FA_W-1:15] == '0));

    // R1: window offset passes through
    assert_win_offset_R1: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[15] |=> (flash_addr[14:0] == $past(cpu_addr[14:0])));

endmodule

bind flash_bank_window fbw_checker #(.BANK_W(BANK_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr_en  (reg_wr_en),
    .reg_sel    (reg_sel),
    .cpu_addr   (cpu_addr),
    .cpu_ea     (cpu_ea),
    .erase_done (erase_done),
    .flash_addr (flash_addr),
    .flash_we   (flash_we),
    .xram_we    (xram_we),
    .bank_q     (bank_q),
    .pwe_q      (pwe_q)
);

// File: tb/sim_flash_bank_window.sv
`timescale 1ns/1ps
module sim_flash_bank_window;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_xwr = 1'b0;
    logic        cpu_ea = 1'b0;
    logic        erase_done = 1'b0;
    logic [17:0] fa0;
    logic [16:0] fa1;
    logic [7:0]  fwd0, fwd1;
    logic        fwe0, xwe0, fwe1, xwe1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flash_bank_window #(.BANK_W(3)) u0 (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_xwr(cpu_xwr), .cpu_ea(cpu_ea), .erase_done(erase_done),
        .flash_addr(fa0), .flash_wdata(fwd0), .flash_we(fwe0), .xram_we(xwe0)
    );

    flash_bank_window #(.BANK_W(2)) u1 (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_xwr(cpu_xwr), .cpu_ea(cpu_ea), .erase_done(erase_done),
        .flash_addr(fa1), .flash_wdata(fwd1), .flash_we(fwe1), .xram_we(xwe1)
    );

    typedef struct packed {
        logic        rw;
        logic        rsel;
        logic [7:0]  rdat;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic        xwr;
        logic        ea;
        logic        er;
        logic [17:0] efa;
        logic        efwe;
        logic        exwe;
        logic [7:0]  ewd;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,8'h05,16'h8123,8'h00,1'b0,1'b0,1'b0,18'h00123,1'b0,1'b0,8'h00}, // R11 old bank
        '{1'b0,1'b0,8'h00,16'h8123,8'h00,1'b0,1'b0,1'b0,18'h28123,1'b0,1'b0,8'h00}, // R1 R3
        '{1'b0,1'b0,8'h00,16'h1234,8'h00,1'b0,1'b0,1'b0,18'h01234,1'b0,1'b0,8'h00}, // R2
        '{1'b0,1'b0,8'h00,16'hFFFF,8'h00,1'b0,1'b0,1'b0,18'h2FFFF,1'b0,1'b0,8'h00}, // R1
        '{1'b0,1'b0,8'h00,16'h9000,8'h3C,1'b1,1'b0,1'b0,18'h29000,1'b0,1'b1,8'h00}, // R5
        '{1'b0,1'b0,8'h00,16'h9000,8'h3C,1'b1,1'b0,1'b0,18'h29000,1'b0,1'b0,8'h00}, // R9 held
        '{1'b1,1'b1,8'h01,16'h9000,8'h00,1'b0,1'b0,1'b0,18'h29000,1'b0,1'b0,8'h00}, // R7 set
        '{1'b0,1'b0,8'h00,16'hA001,8'h5A,1'b1,1'b0,1'b0,18'h2A001,1'b1,1'b0,8'h5A}, // R6
        '{1'b0,1'b0,8'h00,16'hA001,8'h00,1'b0,1'b0,1'b0,18'h2A001,1'b0,1'b0,8'h00}, // R9
        '{1'b0,1'b0,8'h00,16'hA002,8'h77,1'b1,1'b0,1'b0,18'h2A002,1'b1,1'b0,8'h77}, // R8
        '{1'b1,1'b1,8'h00,16'hA002,8'h00,1'b0,1'b1,1'b0,18'h2A002,1'b0,1'b0,8'h00}, // R7 locked
        '{1'b0,1'b0,8'h00,16'h8000,8'h11,1'b1,1'b1,1'b0,18'h28000,1'b1,1'b0,8'h11}, // R7 still flash
        '{1'b1,1'b1,8'h00,16'h8000,8'h00,1'b0,1'b0,1'b0,18'h28000,1'b0,1'b0,8'h00}, // R7 clear
        '{1'b0,1'b0,8'h00,16'h8000,8'h22,1'b1,1'b0,1'b0,18'h28000,1'b0,1'b1,8'h00}, // R5
        '{1'b0,1'b0,8'h00,16'hC000,8'h00,1'b0,1'b0,1'b1,18'h2C000,1'b0,1'b0,8'h00}, // R4 erase
        '{1'b0,1'b0,8'h00,16'hC000,8'h00,1'b0,1'b0,1'b0,18'h04000,1'b0,1'b0,8'h00}, // R4
        '{1'b1,1'b0,8'h07,16'hC000,8'h00,1'b0,1'b0,1'b1,18'h04000,1'b0,1'b0,8'h00}, // R4 priority
        '{1'b0,1'b0,8'h00,16'hC000,8'h00,1'b0,1'b0,1'b0,18'h04000,1'b0,1'b0,8'h00}, // R4
        '{1'b1,1'b0,8'h02,16'h8001,8'h00,1'b0,1'b0,1'b0,18'h00001,1'b0,1'b0,8'h00}, // R11
        '{1'b0,1'b0,8'h00,16'h8001,8'h00,1'b0,1'b0,1'b0,18'h10001,1'b0,1'b0,8'h00}, // R3
        '{1'b1,1'b0,8'hF9,16'h8001,8'h00,1'b0,1'b0,1'b0,18'h10001,1'b0,1'b0,8'h00}, // R3
        '{1'b0,1'b0,8'h00,16'h8001,8'h00,1'b0,1'b0,1'b0,18'h08001,1'b0,1'b0,8'h00}, // R3 upper bits dropped
        '{1'b1,1'b1,8'h01,16'h8002,8'h44,1'b1,1'b0,1'b0,18'h08002,1'b0,1'b1,8'h00}, // R11 old enable
        '{1'b0,1'b0,8'h00,16'h8002,8'h00,1'b0,1'b0,1'b0,18'h08002,1'b0,1'b0,8'h00}, // R9
        '{1'b0,1'b0,8'h00,16'h8003,8'hA5,1'b1,1'b0,1'b0,18'h08003,1'b1,1'b0,8'hA5}, // R6
        '{1'b1,1'b1,8'h00,16'h8003,8'h00,1'b0,1'b0,1'b0,18'h08003,1'b0,1'b0,8'h00}  // R8 sw clear
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        reg_wr_en  = v.rw;
        reg_sel    = v.rsel;
        reg_wdata  = v.rdat;
        cpu_addr   = v.addr;
        cpu_wdata  = v.wd;
        cpu_xwr    = v.xwr;
        cpu_ea     = v.ea;
        erase_done = v.er;
        @(posedge clk);
        #1;
    endtask

    function automatic vec_t idle(input logic [15:0] a, input logic x);
        vec_t v;
        v = '0;
        v.addr = a;
        v.xwr = x;
        return v;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        vec_t v;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check("R10 flash_we", {31'b0, fwe0}, 32'h0);
        check("R10 xram_we", {31'b0, xwe0}, 32'h0);
        check("R10 flash_addr", {14'b0, fa0}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check($sformatf("vec%0d flash_addr", i), {14'b0, fa0}, {14'b0, VECS[i].efa});
            check($sformatf("vec%0d flash_we", i), {31'b0, fwe0}, {31'b0, VECS[i].efwe});
            check($sformatf("vec%0d xram_we", i), {31'b0, xwe0}, {31'b0, VECS[i].exwe});
            if (VECS[i].efwe)
                check($sformatf("vec%0d flash_wdata R6", i), {24'b0, fwd0}, {24'b0, VECS[i].ewd});
        end

        // R3: narrow bank variant keeps only two bits
        v = idle(16'h8456, 1'b0);
        v.rw = 1'b1; v.rdat = 8'h07;
        drive(v);
        drive(idle(16'h8456, 1'b0));
        check("R3 wide bank", {14'b0, fa0}, 32'h38456);
        check("R3 narrow bank", {15'b0, fa1}, 32'h18456);

        // R10: mid-run reset clears bank and enable
        v = idle(16'h8456, 1'b0);
        v.rw = 1'b1; v.rsel = 1'b1; v.rdat = 8'h01;
        drive(v);
        rst = 1'b1;
        drive(idle(16'h8456, 1'b1));
        check("R10 strobes held low", {30'b0, fwe0, xwe0}, 32'h0);
        check("R10 addr held low", {14'b0, fa0}, 32'h0);
        rst = 1'b0;
        drive(idle(16'h8456, 1'b0));
        check("R10 bank cleared", {14'b0, fa0}, 32'h00456);
        drive(idle(16'h8456, 1'b1));
        check("R10 enable cleared xram", {31'b0, xwe0}, 32'h1);
        check("R10 enable cleared flash", {31'b0, fwe0}, 32'h0);
        drive(idle(16'h0000, 1'b0));

        finish_run();
    end

endmodule